// File: doc/BRIEF.md
# PC-Relative Store Sequencer

This block is a small 16-bit multicycle datapath with its own controller. It executes one instruction: store a register to the memory word at the program counter plus a signed 9-bit offset. The datapath holds a program counter, an instruction register and eight general registers. It also has an address adder fed by two operand selectors, an address selector, and an ALU with a pass-through mode. A single shared bus connects these parts to the memory address and memory data staging registers, and a synchronous word memory sits behind them.

A one-cycle `start` pulse launches the sequence, which always takes three cycles, one for each step:

1. The effective address is computed, placed on the bus and captured in the address register.
2. The source register, chosen by instruction bits 11:9, passes through the ALU onto the bus and is captured in the data register.
3. The memory is enabled for a write.

Every register captures on the clock edge, so each step can only use what the step before it captured. The program counter, the instruction register and the register file are loaded directly through side ports; the controller decodes no other instruction.

Top module: `store_direct_unit`

## Requirements
- R1: While reset is held low, and after it is released, `busy`, `done`, `mem_en` and `mem_we` are low, and `mem_addr`, `mem_wdata` and `pc_q` are zero.
- R2: In the cycle after the sequence's first cycle, `mem_addr` equals `pc_q` plus the sign extension of instruction bits 8:0, taken modulo 2^16. Only the address path drives the bus in that first cycle.
- R3: In the third cycle of the sequence, `mem_wdata` equals the register selected by instruction bits 11:9. The value was staged through the ALU pass-through onto the bus, and memory was not enabled.
- R4: `mem_en` and `mem_we` are both high in the third cycle of the sequence only, never earlier.
- R5: `done` is high for exactly one cycle, the third cycle after `start` is taken, together with the memory write.
- R6: After the write, a memory read of that address returns the stored word. `mem_rdata` shows the word at the low `MEM_AW` bits of `mem_addr` one cycle after the address is presented, in read-before-write order.
- R7: The store never changes `pc_q`.
- R8: `start` is taken only while `busy` is low. If `start` is held high during a sequence, no cycle is added or repeated and `done` is not shifted.
- R9: While idle, `mem_addr` and `mem_wdata` hold their last values, even when the program counter, the instruction register or a general register is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch one store sequence |
| pc_ld | input | 1 | Load `pc_in` into the program counter |
| pc_in | input | 16 | Program counter load value |
| ir_ld | input | 1 | Load `ir_in` into the instruction register |
| ir_in | input | 16 | Instruction word: bits 11:9 source register, bits 8:0 signed offset |
| rf_we | input | 1 | Write a general register |
| rf_waddr | input | 3 | General register index |
| rf_wdata | input | 16 | General register write value |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Third cycle of the sequence, memory write issued |
| pc_q | output | 16 | Program counter |
| mem_en | output | 1 | Memory enable for the staged transfer |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | 16 | Memory address register |
| mem_wdata | output | 16 | Memory data register |
| mem_rdata | output | 16 | Registered memory read data at `mem_addr` |

## Verification
The store is tried with six program-counter and offset pairs. A positive and a negative offset from the same base tell a correct sign extension from a zero extension. Two further pairs cross the top and the bottom of the 16-bit space, which exposes a truncated or saturating adder. A zero offset and a mid-range offset complete the set. Each vector selects a different source register holding a distinct value, so a wrong register index, or bits 8:6 chosen in place of bits 11:9, shows up as a wrong stored word. Holding `start` high through a sequence, and reloading the program counter, instruction and registers while idle, separates a controller that restarts or leaks state from one that holds it.

// File: rtl/store_pkg.sv
package store_pkg;

  localparam int unsigned DW   = 16;
  localparam int unsigned RA_W = 3;
  localparam int unsigned NREG = 1 << RA_W;

  typedef enum logic [1:0] {ST_IDLE, ST_EA, ST_MDR, ST_WR} st_state_e;
  typedef enum logic       {A1_PC, A1_BASE} a1_sel_e;
  typedef enum logic [1:0] {A2_ZERO, A2_OFF6, A2_OFF9, A2_OFF11} a2_sel_e;
  typedef enum logic       {MM_ADDER, MM_ZEXT8} mm_sel_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_NOT, ALU_PASSA} alu_op_e;

  typedef struct packed {
    a1_sel_e a1_sel;
    a2_sel_e a2_sel;
    mm_sel_e mm_sel;
    logic    gate_marmux;
    logic    gate_alu;
    logic    ld_mar;
    logic    ld_mdr;
    logic    sr1_hi;
    alu_op_e alu_op;
    logic    mio_en;
    logic    rw_write;
  } ctrl_t;

  // sign-extend the low nbits of raw to a full word
  function automatic logic [DW-1:0] sext_field(input logic [DW-1:0] raw,
                                               input logic [3:0] nbits);
    logic [DW-1:0] shl;
    logic [4:0]    amt;
    amt = 5'd16 - {1'b0, nbits};
    shl = raw << amt;
    return $signed(shl) >>> amt;
  endfunction

  function automatic logic [DW-1:0] alu_eval(input alu_op_e op,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_AND: return a & b;
      ALU_NOT: return ~a;
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/store_ctrl.sv
module store_ctrl
  import store_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output ctrl_t ctl,
  output logic  busy,
  output logic  done
);

  st_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_EA;
      ST_EA:   state_d = ST_MDR;
      ST_MDR:  state_d = ST_WR;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    ctl = '0;
    case (state_q)
      ST_EA: begin
        ctl.a1_sel      = A1_PC;
        ctl.a2_sel      = A2_OFF9;
        ctl.mm_sel      = MM_ADDER;
        ctl.gate_marmux = 1'b1;
        ctl.ld_mar      = 1'b1;
      end
      ST_MDR: begin
        ctl.sr1_hi   = 1'b1;
        ctl.alu_op   = ALU_PASSA;
        ctl.gate_alu = 1'b1;
        ctl.mio_en   = 1'b0;
        ctl.ld_mdr   = 1'b1;
      end
      ST_WR: begin
        ctl.mio_en   = 1'b1;
        ctl.rw_write = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_WR);

endmodule

// File: rtl/store_datapath.sv
module store_datapath
  import store_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  ctrl_t           ctl,
  input  logic            pc_ld,
  input  logic [DW-1:0]   pc_in,
  input  logic            ir_ld,
  input  logic [DW-1:0]   ir_in,
  input  logic            rf_we,
  input  logic [RA_W-1:0] rf_waddr,
  input  logic [DW-1:0]   rf_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   pc_q,
  output logic [DW-1:0]   mar_q,
  output logic [DW-1:0]   mdr_q,
  output logic [DW-1:0]   bus
);

  logic [DW-1:0]   ir_q;
  logic [DW-1:0]   rf_q [NREG];
  logic [RA_W-1:0] sr1_idx, sr2_idx;
  logic [DW-1:0]   sr1_val, sr2_val;
  logic [DW-1:0]   addr1, addr2, adder_out, marmux_out, alu_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_ld) pc_q <= pc_in;
      if (ir_ld) ir_q <= ir_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (rf_we) begin
      rf_q[rf_waddr] <= rf_wdata;
    end
  end

  assign sr1_idx = ctl.sr1_hi ? ir_q[11:9] : ir_q[8:6];
  assign sr2_idx = ir_q[2:0];
  assign sr1_val = rf_q[sr1_idx];
  assign sr2_val = rf_q[sr2_idx];

  assign addr1 = (ctl.a1_sel == A1_PC) ? pc_q : sr1_val;

  always_comb begin
    case (ctl.a2_sel)
      A2_OFF6:  addr2 = sext_field(ir_q, 4'd6);
      A2_OFF9:  addr2 = sext_field(ir_q, 4'd9);
      A2_OFF11: addr2 = sext_field(ir_q, 4'd11);
      default:  addr2 = '0;
    endcase
  end

  assign adder_out  = addr1 + addr2;
  assign marmux_out = (ctl.mm_sel == MM_ADDER) ? adder_out : {8'h00, ir_q[7:0]};
  assign alu_out    = alu_eval(ctl.alu_op, sr1_val, sr2_val);

  always_comb begin
    bus = '0;
    if (ctl.gate_marmux)   bus = marmux_out;
    else if (ctl.gate_alu) bus = alu_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      if (ctl.ld_mar) mar_q <= bus;
      if (ctl.ld_mdr) mdr_q <= ctl.mio_en ? mem_rdata : bus;
    end
  end

endmodule

// File: rtl/store_mem.sv
module store_mem
  import store_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end

endmodule

// File: rtl/store_direct_unit.sv
module store_direct_unit
  import store_pkg::*;
#(
  parameter int unsigned MEM_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        pc_ld,
  input  logic [15:0] pc_in,
  input  logic        ir_ld,
  input  logic [15:0] ir_in,
  input  logic        rf_we,
  input  logic [2:0]  rf_waddr,
  input  logic [15:0] rf_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_q,
  output logic        mem_en,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic [15:0] mem_rdata
);

  ctrl_t         ctl;
  logic [DW-1:0] bus;
  logic          gate_marmux, gate_alu, ld_mar, ld_mdr;

  store_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  store_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .pc_ld     (pc_ld),
    .pc_in     (pc_in),
    .ir_ld     (ir_ld),
    .ir_in     (ir_in),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .mem_rdata (mem_rdata),
    .pc_q      (pc_q),
    .mar_q     (mem_addr),
    .mdr_q     (mem_wdata),
    .bus       (bus)
  );

  store_mem #(.AW(MEM_AW)) u_mem (
    .clk   (clk),
    .en    (ctl.mio_en),
    .we    (ctl.rw_write),
    .addr  (mem_addr[MEM_AW-1:0]),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign mem_en      = ctl.mio_en;
  assign mem_we      = ctl.rw_write;
  assign gate_marmux = ctl.gate_marmux;
  assign gate_alu    = ctl.gate_alu;
  assign ld_mar      = ctl.ld_mar;
  assign ld_mdr      = ctl.ld_mdr;

endmodule

// File: rtl/store_chk.sv
module store_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        gate_marmux,
  input logic        gate_alu,
  input logic        ld_mar,
  input logic        ld_mdr,
  input logic        mem_en,
  input logic        mem_we,
  input logic        pc_ld,
  input logic [15:0] pc_q,
  input logic [15:0] mem_addr
);

  // R2
  one_bus_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gate_marmux, gate_alu}));

  // R3
  mdr_after_mar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mdr |-> $past(ld_mar));

  // R4
  write_after_mdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> $past(ld_mdr));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_en && mem_we));

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_ld) |=> $stable(pc_q));

  // R8
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> ld_mar);

  // R8
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9
  mar_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mem_addr));

endmodule

bind store_direct_unit store_chk i_store_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .gate_marmux (gate_marmux),
  .gate_alu    (gate_alu),
  .ld_mar      (ld_mar),
  .ld_mdr      (ld_mdr),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .pc_ld       (pc_ld),
  .pc_q        (pc_q),
  .mem_addr    (mem_addr)
);

// File: tb/test_store_direct_unit.sv
module test_store_direct_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pc_ld = 1'b0;
  logic [15:0] pc_in = '0;
  logic        ir_ld = 1'b0;
  logic [15:0] ir_in = '0;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_waddr = '0;
  logic [15:0] rf_wdata = '0;
  logic        busy, done, mem_en, mem_we;
  logic [15:0] pc_q, mem_addr, mem_wdata, mem_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  store_direct_unit i_store_direct_unit (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pc_ld(pc_ld), .pc_in(pc_in), .ir_ld(ir_ld), .ir_in(ir_in),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .busy(busy), .done(done), .pc_q(pc_q),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // {pc[15:0], source register[2:0], offset[8:0]}
  localparam logic [27:0] VEC [6] = '{
    {16'h3000, 3'd0, 9'h005},
    {16'h3000, 3'd7, 9'h1FF},
    {16'h0010, 3'd3, 9'h100},
    {16'hFFF0, 3'd5, 9'h0FF},
    {16'h1234, 3'd2, 9'h000},
    {16'h4000, 3'd6, 9'h0AA}
  };

  function automatic logic [15:0] reg_val(input int i);
    return 16'(i * 16'h1111 + 16'h00A5);
  endfunction

  function automatic logic [15:0] expect_ea(input logic [15:0] pc, input logic [8:0] off);
    int signed s;
    s = off[8] ? int'(off) - 512 : int'(off);
    return 16'(int'(pc) + s);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_pc_ir(input logic [15:0] pc, input logic [15:0] ir);
    pc_ld = 1'b1; pc_in = pc; ir_ld = 1'b1; ir_in = ir;
    @(negedge clk);
    pc_ld = 1'b0; ir_ld = 1'b0;
  endtask

  task automatic run_store(input logic [15:0] pc, input logic [2:0] sr,
                           input logic [8:0] off, input bit hold_start);
    logic [15:0] ea, dv;
    ea = expect_ea(pc, off);
    dv = reg_val(int'(sr));
    load_pc_ir(pc, {4'b0011, sr, off});
    start = 1'b1;
    @(negedge clk);                      // cycle 1
    if (!hold_start) start = 1'b0;
    chk("R4 no write in cycle 1", {14'd0, mem_en, mem_we}, 16'd0);
    chk("R5 done low cycle 1", {15'd0, done}, 16'd0);
    @(negedge clk);                      // cycle 2
    chk("R2 effective address", mem_addr, ea);
    chk("R4 no write in cycle 2", {14'd0, mem_en, mem_we}, 16'd0);
    chk("R8 busy in cycle 2", {15'd0, busy}, 16'd1);
    @(negedge clk);                      // cycle 3
    start = 1'b0;
    chk("R3 staged data", mem_wdata, dv);
    chk("R4 write in cycle 3", {14'd0, mem_en, mem_we}, 16'd3);
    chk("R5 done in cycle 3", {15'd0, done}, 16'd1);
    @(negedge clk);                      // idle
    chk("R5 done falls", {15'd0, done}, 16'd0);
    chk("R8 idle after store", {15'd0, busy}, 16'd0);
    @(negedge clk);
    chk("R6 memory read back", mem_rdata, dv);
    chk("R7 pc unchanged", pc_q, pc);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset outputs", {12'd0, busy, done, mem_en, mem_we}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_addr", mem_addr, 16'd0);
    chk("R1 mem_wdata", mem_wdata, 16'd0);
    chk("R1 pc", pc_q, 16'd0);
    chk("R1 flags after release", {12'd0, busy, done, mem_en, mem_we}, 16'd0);

    for (int i = 0; i < 8; i++) begin
      rf_we = 1'b1; rf_waddr = 3'(i); rf_wdata = reg_val(i);
      @(negedge clk);
    end
    rf_we = 1'b0;

    for (int v = 0; v < 6; v++)
      run_store(VEC[v][27:12], VEC[v][11:9], VEC[v][8:0], 1'b0);

    // R8: start held high throughout; sequence length and done unchanged
    run_store(16'h2000, 3'd4, 9'h010, 1'b1);
    @(negedge clk);
    chk("R8 no restart", {15'd0, busy}, 16'd0);

    // R9: reloads while idle leave address and data registers alone
    begin
      logic [15:0] a0, d0;
      a0 = mem_addr; d0 = mem_wdata;
      load_pc_ir(16'h7777, {4'b0011, 3'd1, 9'h033});
      rf_we = 1'b1; rf_waddr = 3'd4; rf_wdata = 16'hDEAD;
      @(negedge clk);
      rf_we = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 address held", mem_addr, a0);
      chk("R9 data held", mem_wdata, d0);
      chk("R9 no memory access", {14'd0, mem_en, mem_we}, 16'd0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule